// File: doc/BRIEF.md
# Synchronous DRAM Burst Timing Core

This block models the device side of a synchronous DRAM command path. A set-mode command stores a 10-bit configuration word. That word selects the number of beats in a burst, the column order within a burst, the read latency (two or three clocks) and an option that makes every write a single-location access. Read and write commands then run bursts against a small internal storage array. The array lets a bench write data and read it back in a loop.

For each beat the block shows the column it accesses. Read data passes through a shift pipeline whose tap is chosen by the programmed latency. An output-enable strobe rises one clock ahead of the first valid word. A new read may be issued on every clock, so bursts placed back to back stream without gaps. A new read or write ends any burst still running. A set-mode command is refused with an error flag when it carries a reserved code, or when a burst or read data is still in flight.

Top module: `sdr_burst_timer`

## Requirements
- R1: After reset, `rvalid_o`, `dq_oe_o`, `acc_o`, `mode_err_o` and `busy_err_o` are 0. The active setting is 1 beat, sequential order, latency 2, and writes follow the burst length.
- R2: The latency field (mode bits [6:4]) accepts only the values 2 and 3. Any other value sets `mode_err_o` and leaves the active setting unchanged.
- R3: Command encoding on `cmd_i` is 00 idle, 01 read, 10 write, 11 set mode. For a read sampled at clock edge n with latency m, `rvalid_o` and the first word on `rdata_o` appear right after edge n+m.
- R4: `dq_oe_o` goes high right after edge n+m-1, one clock before the first valid word. It stays high while `rvalid_o` is high and is low when no read data is due.
- R5: Mode bits [2:0] set the beat count: 000 gives 1, 001 gives 2, 010 gives 4 and 011 gives 8. When mode bit 9 is 0, this count applies to reads and to writes. `acc_o` is high for exactly that many cycles.
- R6: When mode bit 9 is 1, every write accesses exactly one column, while reads still use the programmed beat count.
- R7: Mode bit 3 selects the order of beats. With 0 (sequential), beat k takes the low column bits (start+k) modulo the beat count. With 1 (interleaved), beat k takes the low bits start XOR k. The column bits above the burst block keep their starting value.
- R8: A set-mode word with bits [8:7] not equal to 00, or with bit 2 set (beat-count codes 100 to 111), sets `mode_err_o` and is not adopted.
- R9: A set-mode command that arrives while a burst is running or read data is still pending is ignored, and it sets `busy_err_o`.
- R10: An accepted set-mode command with a legal word clears both `mode_err_o` and `busy_err_o`.
- R11: A read may be issued on every clock. A new read or write ends the running burst at once, and reads spaced by the beat count give a gap-free `rvalid_o`.
- R12: Write data on `wdata_i` is stored at the column shown on `col_o` for that beat. The first beat is taken with the command. A later read returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 2 | Command: 00 idle, 01 read, 10 write, 11 set mode |
| col_i | input | COL_W | Starting column for read or write |
| mode_i | input | 10 | Configuration word taken by set mode |
| wdata_i | input | DATA_W | Write data for the beat issued this cycle |
| acc_o | output | 1 | A beat is issued at the coming edge |
| acc_wr_o | output | 1 | The issued beat is a write |
| col_o | output | COL_W | Column of the issued beat |
| rdata_o | output | DATA_W | Read data word |
| rvalid_o | output | 1 | Read data word is valid |
| dq_oe_o | output | 1 | Data output enable, leading valid by one clock |
| mode_err_o | output | 1 | Sticky flag: reserved configuration refused |
| busy_err_o | output | 1 | Sticky flag: set mode refused while busy |

## Verification
Single reads cover every beat count, both orders, both latencies and starting columns that are not aligned. These cases separate a wrap inside the aligned block from a plain increment, and an XOR order from a sequential one. The bench also issues chains of reads: one every clock, one every beat-count cycles, and one before the previous burst has ended. These distinguish a true shift pipeline from a single-read timer and show when a burst is cut short. The remaining scenarios are writes with the single-location option, refused set-mode words, and a set-mode command issued during a burst. In each of these the bench reads the data back and times it, to show the old setting still governs.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_SETM  = 2'b11
  } cmd_e;

  localparam int MODE_W   = 10;
  localparam int BLK_BITS = 3;   // widest burst block is 8 columns

  // field positions inside the configuration word
  localparam int F_BL_LO  = 0;
  localparam int F_ORDER  = 3;
  localparam int F_LAT_LO = 4;
  localparam int F_OP_LO  = 7;
  localparam int F_WSING  = 9;

  typedef struct packed {
    logic [1:0] blc;       // log2 of beat count
    logic       ilv;       // interleaved order
    logic [1:0] lat;       // 2 or 3
    logic       wr_single; // writes are one beat
  } cfg_t;

endpackage

// File: rtl/sbt_mode_reg.sv
module sbt_mode_reg
  import sbt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              setm,
  input  logic [MODE_W-1:0] word,
  input  logic              busy,
  output logic [1:0]        blc,
  output logic              ilv,
  output logic [1:0]        lat,
  output logic              wr_single,
  output logic              mode_err,
  output logic              busy_err
);

  cfg_t cfg_q, cfg_d, cfg_new;
  logic merr_q, merr_d, berr_q, berr_d;
  logic legal, accept;
  logic [2:0] lat_code;

  always_comb begin
    lat_code = word[F_LAT_LO +: 3];
    legal = !word[F_BL_LO+2] &&
            (lat_code == 3'd2 || lat_code == 3'd3) &&
            (word[F_OP_LO +: 2] == 2'b00);
    accept = setm && !busy && legal;

    cfg_new.blc       = word[F_BL_LO +: 2];
    cfg_new.ilv       = word[F_ORDER];
    cfg_new.lat       = lat_code[1:0];
    cfg_new.wr_single = word[F_WSING];

    cfg_d  = cfg_q;
    merr_d = merr_q;
    berr_d = berr_q;
    if (accept) begin
      cfg_d  = cfg_new;
      merr_d = 1'b0;
      berr_d = 1'b0;
    end else if (setm && busy) begin
      berr_d = 1'b1;
    end else if (setm) begin
      merr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '{blc: 2'd0, ilv: 1'b0, lat: 2'd2, wr_single: 1'b0};
      merr_q <= 1'b0;
      berr_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      merr_q <= merr_d;
      berr_q <= berr_d;
    end
  end

  assign blc       = cfg_q.blc;
  assign ilv       = cfg_q.ilv;
  assign lat       = cfg_q.lat;
  assign wr_single = cfg_q.wr_single;
  assign mode_err  = merr_q;
  assign busy_err  = berr_q;

  a_r9_busy_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (setm && busy) |=> (busy_err && $stable(cfg_q)));

  a_r2_lat_only_two_three: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.lat == 2'd2) || (cfg_q.lat == 2'd3));

  a_r8_reserved_op_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (setm && !busy && word[F_OP_LO +: 2] != 2'b00) |=> (mode_err && $stable(cfg_q)));

  a_r10_clear_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (setm && !busy && legal) |=> (!mode_err && !busy_err));

endmodule

// File: rtl/sbt_burst_seq.sv
module sbt_burst_seq
  import sbt_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd,
  input  logic [COL_W-1:0] col_i,
  input  logic [1:0]       blc,
  input  logic             ilv,
  input  logic             wr_single,
  output logic             iss_v,
  output logic             iss_wr,
  output logic [COL_W-1:0] iss_col,
  output logic             active
);

  localparam int CNT_W = BLK_BITS + 1;

  logic                act_q, act_d;
  logic [BLK_BITS-1:0] beat_q, beat_d;
  logic [CNT_W-1:0]    len_q, len_d;
  logic [COL_W-1:0]    start_q, start_d;
  logic                wr_q, wr_d;

  logic                new_cmd, is_wr;
  logic [CNT_W-1:0]    blen, beat_nx;
  logic [BLK_BITS-1:0] mask, lo, lo_seq, lo_ilv, lo_sel;
  logic [COL_W-1:0]    gen_col;

  // column of the continuing beat
  always_comb begin
    mask    = len_q[BLK_BITS-1:0] - 1'b1;
    lo      = start_q[BLK_BITS-1:0];
    lo_seq  = lo + beat_q;
    lo_ilv  = lo ^ beat_q;
    lo_sel  = ilv ? lo_ilv : lo_seq;
    gen_col = start_q;
    gen_col[BLK_BITS-1:0] = (lo & ~mask) | (lo_sel & mask);
  end

  always_comb begin
    new_cmd = (cmd == CMD_READ) || (cmd == CMD_WRITE);
    is_wr   = (cmd == CMD_WRITE);
    blen    = (is_wr && wr_single) ? CNT_W'(1) : (CNT_W'(1) << blc);
    beat_nx = {1'b0, beat_q} + CNT_W'(1);

    iss_v   = 1'b0;
    iss_wr  = 1'b0;
    iss_col = '0;
    act_d   = act_q;
    beat_d  = beat_q;
    len_d   = len_q;
    start_d = start_q;
    wr_d    = wr_q;

    if (new_cmd) begin
      iss_v   = 1'b1;
      iss_wr  = is_wr;
      iss_col = col_i;
      act_d   = (blen > CNT_W'(1));
      beat_d  = BLK_BITS'(1);
      len_d   = blen;
      start_d = col_i;
      wr_d    = is_wr;
    end else if (act_q) begin
      iss_v   = 1'b1;
      iss_wr  = wr_q;
      iss_col = gen_col;
      act_d   = (beat_nx < len_q);
      beat_d  = beat_nx[BLK_BITS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      beat_q  <= '0;
      len_q   <= CNT_W'(1);
      start_q <= '0;
      wr_q    <= 1'b0;
    end else begin
      act_q   <= act_d;
      beat_q  <= beat_d;
      len_q   <= len_d;
      start_q <= start_d;
      wr_q    <= wr_d;
    end
  end

  assign active = act_q;

  a_r6_write_one_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_WRITE && wr_single) |=> !act_q);

  a_r5_beat_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> ({1'b0, beat_q} < len_q));

  a_r7_stays_in_block: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !new_cmd) |-> (iss_col[COL_W-1:BLK_BITS] == start_q[COL_W-1:BLK_BITS]));

endmodule

// File: rtl/sbt_lat_pipe.sv
module sbt_lat_pipe #(
  parameter int DATA_W  = 16,
  parameter int MAX_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_iss,
  input  logic [DATA_W-1:0] rd_word,
  input  logic [1:0]        lat,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata,
  output logic              oe,
  output logic              pending
);

  localparam int DEPTH = MAX_LAT + 1;

  logic [DEPTH:1]    vld_q, vld_d;
  logic [DATA_W-1:0] dat_q [2:DEPTH];

  always_comb vld_d = {vld_q[DEPTH-1:1], rd_iss};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // data stages carry no reset; each loads only behind a valid flag
  always_ff @(posedge clk) begin
    if (vld_q[1]) dat_q[2] <= rd_word;
    for (int g = 3; g <= DEPTH; g++) begin
      if (vld_q[g-1]) dat_q[g] <= dat_q[g-1];
    end
  end

  always_comb begin
    rvalid = 1'b0;
    oe     = 1'b0;
    rdata  = '0;
    for (int g = 2; g <= DEPTH; g++) begin
      if (g == int'(lat) + 1) begin
        rvalid = vld_q[g];
        oe     = vld_q[g] | vld_q[g-1];
        rdata  = dat_q[g];
      end
    end
  end

  assign pending = |vld_q;

  a_r4_oe_covers_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> oe);

  a_r4_oe_leads_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |-> $past(oe));

  a_r3_lat_two: assert property (@(posedge clk) disable iff (!rst_n)
    (lat == 2'd2 && rvalid) |-> $past(rd_iss, 3));

  a_r3_lat_three: assert property (@(posedge clk) disable iff (!rst_n)
    (lat == 2'd3 && rvalid) |-> $past(rd_iss, 4));

endmodule

// File: rtl/sbt_store.sv
module sbt_store #(
  parameter int COL_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [COL_W-1:0]  addr,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] rq
);

  localparam int WORDS = 1 << COL_W;

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    if (re) rq <= mem[addr];
  end

endmodule

// File: rtl/sdr_burst_timer.sv
module sdr_burst_timer
  import sbt_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              acc_o,
  output logic              acc_wr_o,
  output logic [COL_W-1:0]  col_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              dq_oe_o,
  output logic              mode_err_o,
  output logic              busy_err_o
);

  localparam int MAX_LAT = 3;

  cmd_e              cmd;
  logic [1:0]        blc, lat;
  logic              ilv, wr_single;
  logic              iss_v, iss_wr, seq_active, pend, busy;
  logic [COL_W-1:0]  iss_col;
  logic [DATA_W-1:0] mem_q;

  assign cmd  = cmd_e'(cmd_i);
  assign busy = seq_active | pend;

  sbt_mode_reg u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .setm      (cmd == CMD_SETM),
    .word      (mode_i),
    .busy      (busy),
    .blc       (blc),
    .ilv       (ilv),
    .lat       (lat),
    .wr_single (wr_single),
    .mode_err  (mode_err_o),
    .busy_err  (busy_err_o)
  );

  sbt_burst_seq #(.COL_W(COL_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .col_i     (col_i),
    .blc       (blc),
    .ilv       (ilv),
    .wr_single (wr_single),
    .iss_v     (iss_v),
    .iss_wr    (iss_wr),
    .iss_col   (iss_col),
    .active    (seq_active)
  );

  sbt_store #(.COL_W(COL_W), .DATA_W(DATA_W)) u_store (
    .clk  (clk),
    .we   (iss_v & iss_wr),
    .re   (iss_v & ~iss_wr),
    .addr (iss_col),
    .wd   (wdata_i),
    .rq   (mem_q)
  );

  sbt_lat_pipe #(.DATA_W(DATA_W), .MAX_LAT(MAX_LAT)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_iss  (iss_v & ~iss_wr),
    .rd_word (mem_q),
    .lat     (lat),
    .rvalid  (rvalid_o),
    .rdata   (rdata_o),
    .oe      (dq_oe_o),
    .pending (pend)
  );

  assign acc_o    = iss_v;
  assign acc_wr_o = iss_wr;
  assign col_o    = iss_col;

endmodule

// File: tb/sdr_burst_timer_test.sv
module sdr_burst_timer_test;

  localparam int COL_W  = 8;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [1:0]        cmd_i;
  logic [COL_W-1:0]  col_i;
  logic [9:0]        mode_i;
  logic [DATA_W-1:0] wdata_i;
  logic              acc_o, acc_wr_o, rvalid_o, dq_oe_o, mode_err_o, busy_err_o;
  logic [COL_W-1:0]  col_o;
  logic [DATA_W-1:0] rdata_o;

  int total = 0;
  int bad   = 0;
  logic [DATA_W-1:0] model [256];

  sdr_burst_timer #(.COL_W(COL_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .col_i(col_i), .mode_i(mode_i),
    .wdata_i(wdata_i), .acc_o(acc_o), .acc_wr_o(acc_wr_o), .col_o(col_o),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o), .dq_oe_o(dq_oe_o),
    .mode_err_o(mode_err_o), .busy_err_o(busy_err_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] mw(int bl, int il, int cl, int op, int wb);
    return {wb[0], op[1:0], cl[2:0], il[0], bl[2:0]};
  endfunction

  function automatic int seq_col(int start, int k, int len, bit il);
    int mask = len - 1;
    int lo   = start & 7;
    int sel  = il ? (lo ^ k) : (lo + k);
    return ((start & ~mask) | (sel & mask)) & 8'hFF;
  endfunction

  // called at a negedge; leaves the bench at a negedge
  task automatic set_mode(input logic [9:0] w, input bit e_merr, input bit e_berr, input string req);
    cmd_i = 2'b11; mode_i = w;
    @(negedge clk);
    cmd_i = 2'b00;
    #1;
    chk(mode_err_o == e_merr, req, mode_err_o, e_merr);
    chk(busy_err_o == e_berr, req, busy_err_o, e_berr);
  endtask

  task automatic write_burst(input int start, input int len, input int base, input string req);
    cmd_i = 2'b10; col_i = start[7:0]; wdata_i = base[15:0];
    #1;
    chk(acc_o && acc_wr_o, req, {acc_o, acc_wr_o}, 3);
    chk(col_o == seq_col(start, 0, len, 0), req, col_o, seq_col(start, 0, len, 0));
    model[seq_col(start, 0, len, 0)] = base[15:0];
    for (int k = 1; k < len; k++) begin
      @(negedge clk);
      cmd_i = 2'b00; wdata_i = 16'(base + k);
      #1;
      chk(acc_o && acc_wr_o, req, {acc_o, acc_wr_o}, 3);
      chk(col_o == seq_col(start, k, len, 0), req, col_o, seq_col(start, k, len, 0));
      model[seq_col(start, k, len, 0)] = 16'(base + k);
    end
    @(negedge clk);
    cmd_i = 2'b00;
    #1;
    chk(!acc_o, {req, " beat count"}, acc_o, 0);
  endtask

  // n reads, one every gap cycles, starting columns base, base+stride, ...
  task automatic stream(input int base, input int stride, input int n, input int gap,
                        input int len, input bit il, input int lat, input string req);
    int words = (n - 1) * gap + len;
    cmd_i = 2'b01; col_i = base[7:0];
    for (int j = 0; j <= lat + words + 1; j++) begin
      bit ev, ev_next;
      int w, c, beat, ecol;
      @(negedge clk);
      #1;
      w = j - lat;
      ev = (w >= 0) && (w < words);
      ev_next = (w + 1 >= 0) && (w + 1 < words);
      chk(rvalid_o == ev, "R3 valid timing", rvalid_o, ev);
      chk(dq_oe_o == (ev | ev_next), "R4 output enable", dq_oe_o, ev | ev_next);
      if (ev) begin
        c = w / gap;
        if (c > n - 1) c = n - 1;
        beat = w - c * gap;
        ecol = seq_col(base + c * stride, beat, len, il);
        chk(rdata_o == model[ecol], req, rdata_o, model[ecol]);
      end
      if (((j + 1) % gap == 0) && ((j + 1) / gap < n)) begin
        cmd_i = 2'b01; col_i = 8'(base + ((j + 1) / gap) * stride);
      end else begin
        cmd_i = 2'b00;
      end
    end
  endtask

  task automatic t_reset_defaults();
    #1;
    chk(!rvalid_o && !dq_oe_o && !acc_o, "R1 outputs idle", {rvalid_o, dq_oe_o, acc_o}, 0);
    chk(!mode_err_o && !busy_err_o, "R1 flags clear", {mode_err_o, busy_err_o}, 0);
    write_burst(8'h10, 1, 16'h5A5A, "R1 default one beat");
    stream(8'h10, 0, 1, 1, 1, 0, 2, "R1 default read");
  endtask

  task automatic t_fill();
    set_mode(mw(3, 0, 2, 0, 0), 0, 0, "R5 set eight beats");
    for (int b = 0; b < 32; b++) write_burst(b * 8 + (b % 8), 8, b * 256, "R12 R7 R5 fill");
  endtask

  task automatic t_single_reads();
    set_mode(mw(3, 0, 2, 0, 0), 0, 0, "R5");
    stream(8'h25, 0, 1, 1, 8, 0, 2, "R7 R5 eight sequential");
    set_mode(mw(2, 1, 3, 0, 0), 0, 0, "R7");
    stream(8'h46, 0, 1, 1, 4, 1, 3, "R7 four interleaved");
    set_mode(mw(3, 1, 3, 0, 0), 0, 0, "R7");
    stream(8'h9D, 0, 1, 1, 8, 1, 3, "R7 eight interleaved");
    set_mode(mw(1, 0, 3, 0, 0), 0, 0, "R5");
    stream(8'h13, 0, 1, 1, 2, 0, 3, "R5 two beats");
    set_mode(mw(0, 0, 2, 0, 0), 0, 0, "R5");
    stream(8'h7F, 0, 1, 1, 1, 0, 2, "R5 one beat");
  endtask

  task automatic t_write_single();
    set_mode(mw(2, 0, 2, 0, 1), 0, 0, "R6");
    write_burst(8'h32, 1, 16'hBEEF, "R6 single write");
    stream(8'h32, 0, 1, 1, 4, 0, 2, "R6 read keeps four beats");
    set_mode(mw(2, 0, 2, 0, 0), 0, 0, "R5");
    write_burst(8'h35, 4, 16'hC000, "R5 write burst four");
    stream(8'h35, 0, 1, 1, 4, 0, 2, "R12 readback");
  endtask

  task automatic t_reserved();
    set_mode(mw(1, 0, 3, 0, 0), 0, 0, "R10");
    set_mode(mw(1, 0, 1, 0, 0), 1, 0, "R2 latency code one");
    stream(8'h51, 0, 1, 1, 2, 0, 3, "R2 setting kept");
    set_mode(mw(3, 1, 4, 0, 0), 1, 0, "R2 latency code four");
    set_mode(mw(3, 1, 2, 1, 0), 1, 0, "R8 op bits");
    set_mode(mw(5, 1, 2, 0, 0), 1, 0, "R8 beat code five");
    stream(8'h61, 0, 1, 1, 2, 0, 3, "R8 setting kept");
    set_mode(mw(2, 0, 2, 0, 0), 0, 0, "R10 clears mode flag");
    stream(8'h66, 0, 1, 1, 4, 0, 2, "R10 new setting");
  endtask

  task automatic t_busy();
    set_mode(mw(3, 0, 2, 0, 0), 0, 0, "R9");
    cmd_i = 2'b01; col_i = 8'h50;
    @(negedge clk);
    cmd_i = 2'b11; mode_i = mw(0, 0, 3, 0, 0);
    @(negedge clk);
    cmd_i = 2'b00;
    repeat (14) @(negedge clk);
    #1;
    chk(busy_err_o == 1'b1, "R9 busy flag", busy_err_o, 1);
    chk(mode_err_o == 1'b0, "R9 no mode flag", mode_err_o, 0);
    stream(8'h83, 0, 1, 1, 8, 0, 2, "R9 setting kept");
    set_mode(mw(0, 0, 2, 0, 0), 0, 0, "R10 clears busy flag");
  endtask

  task automatic t_streams();
    set_mode(mw(0, 0, 2, 0, 0), 0, 0, "R11");
    stream(8'h60, 1, 6, 1, 1, 0, 2, "R11 read every clock");
    set_mode(mw(1, 0, 3, 0, 0), 0, 0, "R11");
    stream(8'h21, 8, 4, 2, 2, 0, 3, "R11 gapless two beat");
    set_mode(mw(3, 1, 2, 0, 0), 0, 0, "R11");
    stream(8'hA2, 16, 3, 3, 8, 1, 2, "R11 cut short");
  endtask

  initial begin
    rst_n = 1'b0; cmd_i = 2'b00; col_i = '0; mode_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_defaults();
    t_fill();
    t_single_reads();
    t_write_single();
    t_reserved();
    t_busy();
    t_streams();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule